// File: doc/BRIEF.md
# Microwire Half-Duplex Serial Master

This block is a synchronous serial master for the Microwire message-passing link. A message is half-duplex. The master pulls its active-low frame line low and shifts a command word out on the transmit line, most significant bit first. The command is 8 or 16 bits long. The link then waits for one bit period with the transmit line low. After that, the peripheral answers with a response word, also most significant bit first, on a separate receive line. The serial clock is low between messages. Its first rising edge falls midway through the first command bit, and it then toggles at the bit rate.

On the parallel side, a command enters through a valid/ready handshake. The received word leaves with a one-cycle valid pulse and is right-aligned. The half-period of the serial clock is `cfg_div + 1` system clocks. A command that arrives while a message is in flight is parked. If it was accepted before the last response bit was sampled, it chains onto the current message without raising the frame line.

The controller uses five states:
- ST_IDLE: the lines are quiet. A valid command (start) leads to ST_CMD.
- ST_CMD: the command bits are shifted out. The last command slot (cmd_done) leads to ST_GAP.
- ST_GAP: one silent bit period. Its end (gap_done) leads to ST_RESP.
- ST_RESP: the response bits are sampled. The last slot leads either to ST_CMD (chain, when a command is parked) or to ST_TAIL (finish).
- ST_TAIL: a half period with the clock low. Its end (release) leads to ST_IDLE.

Top module: `mw_master`

## Requirements
- R1: While no message is in progress, `frame_n` is 1, `sclk` is 0, `txd` is 0 and `busy` is 0. While `frame_n` is 0, `busy` is 1.
- R2: An accepted command drives `frame_n` low. The command bits then appear on `txd`, MSB first. With `cfg_cmd16`=1 the command is `cmd_data[15:0]` (16 bits). With `cfg_cmd16`=0 it is `cmd_data[7:0]` (8 bits).
- R3: The first rising edge of `sclk` comes `cfg_div+1` system clocks after `frame_n` falls. Inside a frame, successive rising edges are exactly `2*(cfg_div+1)` system clocks apart.
- R4: Exactly one bit period with `txd` low separates the last command bit from the first response bit. `txd` also stays low while the response is received.
- R5: The response is sampled on the rising edges of `sclk`, MSB first. Its length is `cfg_rlen+1` bits, and values of `cfg_rlen` below 3 count as 3, so the length runs from 4 to 16 bits. `rx_data` holds the word right-aligned with zeros above it. `rx_valid` is a single-cycle pulse.
- R6: After the last response bit, `sclk` stays low. `frame_n` rises `cfg_div+1` clocks after the last falling edge of `sclk`. A single message holds `frame_n` low for `2*(cfg_div+1)*(N+1+M)+(cfg_div+1)` clocks, where N is the command length and M is the response length.
- R7: A parked command chains onto the current message. `frame_n` stays low, the clock continues without a break, and the next command's MSB starts right after the previous response ends.
- R8: `cmd_ready` is 0 in two cases: once the last response bit has been sampled, until the frame ends, and while a parked command is waiting. A command offered in that window starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd16 | input | 1 | Command length select: 1 means 16 bits, 0 means 8 bits |
| cfg_rlen | input | 4 | Response length minus one (minimum 3) |
| cfg_div | input | 8 | Half-period of the serial clock minus one, in system clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_data | input | 16 | Command word |
| rx_valid | output | 1 | One-cycle pulse: a response word is ready |
| rx_data | output | 16 | Response word, right-aligned |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| frame_n | output | 1 | Active-low frame |
| txd | output | 1 | Serial command out |
| rxd | input | 1 | Serial response in |

## Verification
The message path is tried with 8-bit and 16-bit commands, with response lengths of 4, 6, 8, 12 and 16 bits, and with dividers from 0 to 3. Each combination shows whether the slot counts, the half-period timing and the receive alignment are independent of one another. One run uses a response length below the minimum, to show the clamp. A second command offered while the first is still shifting shows whether chaining keeps the frame line low with an unbroken clock. A command offered just after the last sample shows whether the late-acceptance window opens a fresh frame instead.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_RESP,
        ST_TAIL
    } mw_state_e;
endpackage

// File: rtl/mw_half_timer.sv
module mw_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_i,
    output logic             half_end
);
    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt  <= '0;
            div_q <= '0;
        end else if (restart) begin
            hcnt  <= div_i;
            div_q <= div_i;
        end else if (run) begin
            if (hcnt == '0) hcnt <= div_q;
            else            hcnt <= hcnt - 1'b1;
        end
    end

    assign half_end = run && (hcnt == '0);

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (hcnt == '0) && !restart) |=> (hcnt == div_q));
endmodule

// File: rtl/mw_shift_unit.sv
module mw_shift_unit #(
    parameter int MAX_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             from_pend,
    input  logic             cmd16,
    input  logic [MAX_W-1:0] cmd_data,
    input  logic             park,
    input  logic             shift,
    input  logic             sample,
    input  logic             last_sample,
    input  logic             rxd,
    output logic             tx_bit,
    output logic             rx_valid,
    output logic [MAX_W-1:0] rx_data
);
    localparam int PAD_W = MAX_W - SHORT_W;

    logic [MAX_W-1:0] pend_q;
    logic [MAX_W-1:0] tx_sr;
    logic [MAX_W-1:0] rx_sr;
    logic [MAX_W-1:0] src;
    logic [MAX_W-1:0] src_aligned;

    always_comb begin
        src = from_pend ? pend_q : cmd_data;
        if (cmd16) src_aligned = src;
        else       src_aligned = {src[SHORT_W-1:0], {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (park) begin
            pend_q <= cmd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= src_aligned;
            rx_sr <= '0;
        end else begin
            if (shift)  tx_sr <= {tx_sr[MAX_W-2:0], 1'b0};
            if (sample) rx_sr <= {rx_sr[MAX_W-2:0], rxd};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= last_sample;
            if (last_sample) rx_data <= {rx_sr[MAX_W-2:0], rxd};
        end
    end

    assign tx_bit = tx_sr[MAX_W-1];

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int MAX_W   = 16,
    parameter int SHORT_W = 8,
    parameter int LEN_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cfg_cmd16,
    input  logic [LEN_W-1:0] cfg_rlen,
    input  logic             half_end,
    output logic             cmd_ready,
    output logic             new_msg,
    output logic             from_pend,
    output logic             park,
    output logic             shift_tx,
    output logic             sample_rx,
    output logic             last_sample,
    output logic             tmr_run,
    output logic             sclk_o,
    output logic             frame_n_o,
    output logic             tx_gate,
    output logic             busy_o
);
    localparam logic [LEN_W-1:0] MIN_LEN   = LEN_W'(3);
    localparam logic [LEN_W-1:0] LONG_TOP  = LEN_W'(MAX_W - 1);
    localparam logic [LEN_W-1:0] SHORT_TOP = LEN_W'(SHORT_W - 1);

    mw_state_e        state, state_d;
    logic             ph;
    logic [LEN_W-1:0] bitn;
    logic [LEN_W-1:0] len_q;
    logic             pend_valid;
    logic             in_frame;
    logic             last_bit;
    logic             slot_end;
    logic             rise_edge;
    logic             start_idle;
    logic             start_chain;

    always_comb begin
        in_frame    = (state == ST_CMD) || (state == ST_GAP) || (state == ST_RESP);
        last_bit    = (bitn == '0);
        slot_end    = in_frame && half_end && ph;
        rise_edge   = in_frame && half_end && !ph;
        start_idle  = (state == ST_IDLE) && cmd_valid;
        start_chain = (state == ST_RESP) && slot_end && last_bit && pend_valid;
        new_msg     = start_idle || start_chain;
        from_pend   = start_chain;
        cmd_ready   = (state == ST_IDLE) ||
                      (!pend_valid && ((state == ST_CMD) || (state == ST_GAP) ||
                                       ((state == ST_RESP) && !(last_bit && ph))));
        park        = cmd_valid && cmd_ready && (state != ST_IDLE);
        shift_tx    = (state == ST_CMD) && slot_end;
        sample_rx   = (state == ST_RESP) && rise_edge;
        last_sample = sample_rx && last_bit;
        tmr_run     = (state != ST_IDLE);
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (cmd_valid)             state_d = ST_CMD;
            ST_CMD:  if (slot_end && last_bit)  state_d = ST_GAP;
            ST_GAP:  if (slot_end)              state_d = ST_RESP;
            ST_RESP: if (slot_end && last_bit)  state_d = pend_valid ? ST_CMD : ST_TAIL;
            ST_TAIL: if (half_end)              state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= 1'b0;
            bitn  <= '0;
            len_q <= MIN_LEN;
        end else if (new_msg) begin
            ph    <= 1'b0;
            bitn  <= cfg_cmd16 ? LONG_TOP : SHORT_TOP;
            len_q <= (cfg_rlen < MIN_LEN) ? MIN_LEN : cfg_rlen;
        end else if (in_frame && half_end) begin
            ph <= ~ph;
            if (ph) begin
                unique case (state)
                    ST_CMD:  if (!last_bit) bitn <= bitn - 1'b1;
                    ST_GAP:  bitn <= len_q;
                    ST_RESP: if (!last_bit) bitn <= bitn - 1'b1;
                    default: bitn <= bitn;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pend_valid <= 1'b0;
        else if (start_chain) pend_valid <= 1'b0;
        else if (park)        pend_valid <= 1'b1;
    end

    always_comb begin
        sclk_o    = in_frame && ph;
        frame_n_o = (state == ST_IDLE);
        tx_gate   = (state == ST_CMD);
        busy_o    = (state != ST_IDLE);
    end

    // R7
    chain_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_chain |=> ((state == ST_CMD) && !frame_n_o && !pend_valid && !sclk_o));

    // R6
    tail_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n_o) |-> (!sclk_o && ($past(state) == ST_TAIL)));

    // R8
    park_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> (pend_valid && !cmd_ready));

    // R4
    gap_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_GAP) && slot_end) |=> (state == ST_RESP));
endmodule

// File: rtl/mw_master.sv
module mw_master #(
    parameter int MAX_W   = 16,
    parameter int SHORT_W = 8,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cmd16,
    input  logic [LEN_W-1:0] cfg_rlen,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [MAX_W-1:0] cmd_data,
    output logic             rx_valid,
    output logic [MAX_W-1:0] rx_data,
    output logic             busy,
    output logic             sclk,
    output logic             frame_n,
    output logic             txd,
    input  logic             rxd
);
    logic new_msg, from_pend, park, shift_tx, sample_rx, last_sample;
    logic tmr_run, half_end, tx_gate, tx_bit;

    mw_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (new_msg),
        .run      (tmr_run),
        .div_i    (cfg_div),
        .half_end (half_end)
    );

    mw_ctrl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cfg_cmd16   (cfg_cmd16),
        .cfg_rlen    (cfg_rlen),
        .half_end    (half_end),
        .cmd_ready   (cmd_ready),
        .new_msg     (new_msg),
        .from_pend   (from_pend),
        .park        (park),
        .shift_tx    (shift_tx),
        .sample_rx   (sample_rx),
        .last_sample (last_sample),
        .tmr_run     (tmr_run),
        .sclk_o      (sclk),
        .frame_n_o   (frame_n),
        .tx_gate     (tx_gate),
        .busy_o      (busy)
    );

    mw_shift_unit #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (new_msg),
        .from_pend   (from_pend),
        .cmd16       (cfg_cmd16),
        .cmd_data    (cmd_data),
        .park        (park),
        .shift       (shift_tx),
        .sample      (sample_rx),
        .last_sample (last_sample),
        .rxd         (rxd),
        .tx_bit      (tx_bit),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data)
    );

    assign txd = tx_gate && tx_bit;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_n |-> (!sclk && !txd && !busy));
endmodule

// File: tb/mw_master_tb.sv
module mw_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cmd16 = 1'b0;
    logic [3:0]  cfg_rlen = 4'd7;
    logic [7:0]  cfg_div = 8'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = 16'h0;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        busy, sclk, frame_n, txd;
    logic        rxd = 1'b0;

    always #4 clk = ~clk;

    mw_master u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cmd16(cfg_cmd16), .cfg_rlen(cfg_rlen),
        .cfg_div(cfg_div), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_data(rx_data),
        .busy(busy), .sclk(sclk), .frame_n(frame_n), .txd(txd), .rxd(rxd)
    );

    int total = 0;
    int fails = 0;
    int cur_n = 8, cur_m = 8, cur_h = 1;
    int cyc = 0, t_fall = 0, t_rise = 0, have_rise = 0, r_cnt = 0, mi = 0;
    int frame_falls = 0, frame_rises = 0, frame_len = 0, first_dly = 0;
    int period_err = 0, gap_err = 0, idle_err = 0, pulse_err = 0, rxv_cnt = 0;
    logic prev_fn = 1'b1, prev_sclk = 1'b0, prev_rxv = 1'b0;
    logic [15:0] cap [0:3];
    logic [15:0] resp [0:3];
    logic [15:0] rxw [0:3];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_fn && !frame_n) begin frame_falls++; t_fall = cyc; have_rise = 0; end
            if (!prev_fn && frame_n) begin frame_rises++; frame_len = cyc - t_fall; end
            if (frame_n && (sclk || txd || busy)) idle_err++;
            if (!frame_n && !busy) idle_err++;
            if (!prev_sclk && sclk) begin
                if (have_rise == 0) first_dly = cyc - t_fall;
                else if (cyc - t_rise != 2 * cur_h) period_err++;
                have_rise = 1;
                t_rise = cyc;
                r_cnt++;
                if (r_cnt <= cur_n) cap[mi] = {cap[mi][14:0], txd};
                else if (txd) gap_err++;
            end
            if (prev_sclk && !sclk) begin
                if (r_cnt >= cur_n + 1 && r_cnt < cur_n + 1 + cur_m)
                    rxd = resp[mi][cur_m - 1 - (r_cnt - cur_n - 1)];
                else
                    rxd = 1'b0;
                if (r_cnt == cur_n + 1 + cur_m) begin
                    r_cnt = 0;
                    if (mi < 3) mi++;
                end
            end
            if (rx_valid) begin
                if (prev_rxv) pulse_err++;
                if (rxv_cnt < 4) rxw[rxv_cnt] = rx_data;
                rxv_cnt++;
            end
        end
        prev_fn = frame_n;
        prev_sclk = sclk;
        prev_rxv = rx_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic clr_mon();
        frame_falls = 0; frame_rises = 0; frame_len = 0; first_dly = 0;
        period_err = 0; gap_err = 0; idle_err = 0; pulse_err = 0; rxv_cnt = 0;
        r_cnt = 0; mi = 0; have_rise = 0;
        for (int i = 0; i < 4; i++) begin cap[i] = 16'h0; rxw[i] = 16'h0; end
    endtask

    task automatic setup(input bit c16, input logic [3:0] rl, input logic [7:0] dv);
        cfg_cmd16 = c16;
        cfg_rlen = rl;
        cfg_div = dv;
        cur_n = c16 ? 16 : 8;
        cur_m = (rl < 4'd3) ? 4 : int'(rl) + 1;
        cur_h = int'(dv) + 1;
    endtask

    task automatic send(input logic [15:0] d);
        @(negedge clk);
        cmd_data = d;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        int k = 0;
        while (frame_rises < n && k < 20000) begin @(negedge clk); k++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(frame_n == 1'b1, "R1 reset frame_n", int'(frame_n), 1);
        chk(sclk == 1'b0, "R1 reset sclk", int'(sclk), 0);
        chk(txd == 1'b0, "R1 reset txd", int'(txd), 0);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(cmd_ready == 1'b1, "R8 reset ready", int'(cmd_ready), 1);
        chk(rx_valid == 1'b0, "R5 reset rx_valid", int'(rx_valid), 0);
    endtask

    task automatic t_single(input bit c16, input logic [3:0] rl, input logic [7:0] dv,
                            input logic [15:0] d, input logic [15:0] r);
        logic [15:0] exp_cmd;
        logic [15:0] mask;
        clr_mon();
        setup(c16, rl, dv);
        resp[0] = r;
        send(d);
        wait_rises(1);
        exp_cmd = c16 ? d : {8'h0, d[7:0]};
        mask = 16'((32'd1 << cur_m) - 1);
        chk(cap[0] == exp_cmd, "R2 command bits", int'(cap[0]), int'(exp_cmd));
        chk(first_dly == cur_h, "R3 first rise delay", first_dly, cur_h);
        chk(period_err == 0, "R3 clock period", period_err, 0);
        chk(gap_err == 0, "R4 txd low in gap/response", gap_err, 0);
        chk(rxv_cnt == 1 && pulse_err == 0, "R5 single rx pulse", rxv_cnt, 1);
        chk(rxw[0] == (r & mask), "R5 response word", int'(rxw[0]), int'(r & mask));
        chk(frame_len == 2 * cur_h * (cur_n + 1 + cur_m) + cur_h, "R6 frame length",
            frame_len, 2 * cur_h * (cur_n + 1 + cur_m) + cur_h);
        chk(idle_err == 0, "R1 idle lines/busy", idle_err, 0);
    endtask

    task automatic t_chain();
        clr_mon();
        setup(1'b0, 4'd5, 8'd1);
        resp[0] = 16'h002B;
        resp[1] = 16'h0015;
        send(16'h003C);
        send(16'h00E7);
        chk(cmd_ready == 1'b0, "R8 ready low while parked", int'(cmd_ready), 0);
        wait_rises(1);
        chk(frame_falls == 1, "R7 one frame for two messages", frame_falls, 1);
        chk(cap[0] == 16'h003C, "R7 first command", int'(cap[0]), 'h3C);
        chk(cap[1] == 16'h00E7, "R7 chained command", int'(cap[1]), 'hE7);
        chk(rxw[0] == 16'h002B && rxw[1] == 16'h0015, "R7 both responses",
            int'({rxw[0][7:0], rxw[1][7:0]}), 'h2B15);
        chk(period_err == 0, "R7 unbroken clock", period_err, 0);
        chk(frame_len == 4 * cur_h * (cur_n + 1 + cur_m) + cur_h, "R7 chained frame length",
            frame_len, 4 * cur_h * (cur_n + 1 + cur_m) + cur_h);
    endtask

    task automatic t_late();
        int k = 0;
        clr_mon();
        setup(1'b0, 4'd7, 8'd0);
        resp[0] = 16'h00C6;
        resp[1] = 16'h0039;
        send(16'h0055);
        while (rxv_cnt < 1 && k < 20000) begin @(negedge clk); k++; end
        chk(cmd_ready == 1'b0, "R8 ready low after last sample", int'(cmd_ready), 0);
        chk(busy == 1'b1, "R8 busy until frame end", int'(busy), 1);
        send(16'h000F);
        wait_rises(2);
        chk(frame_falls == 2, "R8 late command opens new frame", frame_falls, 2);
        chk(cap[1] == 16'h000F && rxw[1] == 16'h0039, "R8 late message contents",
            int'({cap[1][7:0], rxw[1][7:0]}), 'h0F39);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(1'b0, 4'd7, 8'd1, 16'hA5C3, 16'h005A);
        t_single(1'b1, 4'd11, 8'd0, 16'hB38E, 16'h09C5);
        t_single(1'b0, 4'd0, 8'd3, 16'h0081, 16'h000B);
        t_single(1'b1, 4'd15, 8'd2, 16'h7E01, 16'hF00D);
        t_chain();
        t_late();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule